// File: doc/BRIEF.md
# Sexagesimal Event Counter

This block counts input events in a mixed radix of ten and six. A decimal units digit advances by one on every clock in which the event enable is high. A tens digit advances only when the units digit rolls over. Together the two digits run from 00 to 59 and then return to 00. This fits the seconds or minutes section of a clock, or any divide-by-60 prescaler.

Two taps are brought out. The units carry is high for one clock out of every ten enabled events. The terminal pulse is high for one clock out of every sixty. Each digit returns straight to zero from its top value. The count that would equal a digit's modulus never reaches a register or a port. Display decoding is handled outside the block.

The event enable is a plain qualifier. It has no handshake and there is no back-pressure: the counter accepts an event in every clock in which the enable is high and reset is low.

Top module: `sexagesimal_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both digits are 0 after that edge. Both pulse outputs are low for the whole time `rst` is high.
- R2: In a clock where `evt_en` is low and `rst` is low, neither digit changes at the following edge.
- R3: In a clock where `evt_en` is high, `rst` is low and `units` is below 9, `units` increases by exactly one at the following edge.
- R4: `units` is always a BCD value from 0 to 9. An enabled event at 9 takes it directly to 0, so the value 10 (binary 1010) never appears.
- R5: `tens` changes only at an edge where `carry10` was high. There it increases by one, or goes from 5 directly to 0.
- R6: `tens` never exceeds 5. Bit 3 of `tens` (its most significant bit) always reads 0.
- R7: `carry10` is high exactly in those clocks where `evt_en` is high, `rst` is low and `units` equals 9.
- R8: `tick60` is high exactly in those clocks where `carry10` is high and `tens` equals 5. After such a clock, both digits are 0.
- R9: Over 600 consecutive enabled events that start from 00, `carry10` is high in exactly 60 clocks and `tick60` in exactly 10.
- R10: Reset takes priority over `evt_en`. With both high, the digits clear and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_en | input | 1 | One input event is counted in each clock this is high |
| units | output | 4 | Units digit, BCD 0 to 9 |
| tens | output | 4 | Tens digit, 0 to 5, bit 3 always 0 |
| carry10 | output | 1 | Units rollover pulse, one tenth of the event rate |
| tick60 | output | 1 | Full-cycle pulse, one sixtieth of the event rate |

## Verification
The hardest condition to reach is the double rollover at 59. There `tick60` must rise, both digits must clear together, and the tens digit must not pass through 6. Reaching it takes fifty-nine enabled events before the one that matters. The stimulus therefore drives long unbroken runs of enabled cycles through several full cycles. It also mixes in idle gaps, and it asserts reset while the enable is high in the middle of a count. This confirms that holding and reset priority leave the rollover alignment intact.

// File: rtl/sexa_pkg.sv
package sexa_pkg;
  localparam int DIGIT_W   = 4;
  localparam int UNITS_MOD = 10;
  localparam int TENS_MOD  = 6;

  function automatic int bits_for(input int modulus);
    int n;
    n = 1;
    while ((1 << n) < modulus) n++;
    return n;
  endfunction
endpackage

// File: rtl/cascade_digit.sv
module cascade_digit #(
  parameter int MOD = 10,
  parameter int W   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // wrap marks the step that returns this digit to zero
  assign wrap = adv && (value == LAST);

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (adv)  value <= wrap ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/sexagesimal_counter.sv
module sexagesimal_counter
  import sexa_pkg::*;
#(
  parameter int UNITS_MODULUS = UNITS_MOD,
  parameter int TENS_MODULUS  = TENS_MOD,
  parameter int OUT_W         = DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_en,
  output logic [OUT_W-1:0] units,
  output logic [OUT_W-1:0] tens,
  output logic             carry10,
  output logic             tick60
);
  localparam int UW = bits_for(UNITS_MODULUS);
  localparam int TW = bits_for(TENS_MODULUS);

  logic          evt;
  logic [UW-1:0] u_q;
  logic [TW-1:0] t_q;
  logic          u_wrap, t_wrap;

  // reset wins over the event qualifier, so no pulse leaks during reset
  assign evt = evt_en & ~rst;

  cascade_digit #(.MOD(UNITS_MODULUS), .W(UW)) u_units (
    .clk(clk), .rst(rst), .adv(evt), .value(u_q), .wrap(u_wrap)
  );

  cascade_digit #(.MOD(TENS_MODULUS), .W(TW)) u_tens (
    .clk(clk), .rst(rst), .adv(u_wrap), .value(t_q), .wrap(t_wrap)
  );

  generate
    if (OUT_W > UW) begin : g_u_pad
      assign units = {{(OUT_W-UW){1'b0}}, u_q};
    end else begin : g_u_fit
      assign units = OUT_W'(u_q);
    end
    if (OUT_W > TW) begin : g_t_pad
      assign tens = {{(OUT_W-TW){1'b0}}, t_q};
    end else begin : g_t_fit
      assign tens = OUT_W'(t_q);
    end
  endgenerate

  assign carry10 = u_wrap;
  assign tick60  = t_wrap;
endmodule

// File: rtl/sexa_checker.sv
module sexa_checker (
  input logic       clk,
  input logic       rst,
  input logic       evt_en,
  input logic [3:0] units,
  input logic [3:0] tens,
  input logic       carry10,
  input logic       tick60
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (units == 4'd0 && tens == 4'd0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !evt_en |=> ($stable(units) && $stable(tens)));

  a_r3_units_step: assert property (@(posedge clk) disable iff (rst)
    (evt_en && units < 4'd9) |=> (units == $past(units) + 4'd1));

  a_r4_units_bcd: assert property (@(posedge clk) disable iff (rst)
    units <= 4'd9);

  a_r5_tens_only_on_carry: assert property (@(posedge clk) disable iff (rst)
    !carry10 |=> $stable(tens));

  a_r5_tens_advance: assert property (@(posedge clk) disable iff (rst)
    (carry10 && tens < 4'd5) |=> (tens == $past(tens) + 4'd1));

  a_r6_tens_range: assert property (@(posedge clk) disable iff (rst)
    (tens <= 4'd5) && !tens[3]);

  a_r8_tick_clears: assert property (@(posedge clk) disable iff (rst)
    tick60 |=> (units == 4'd0 && tens == 4'd0));

  a_r8_tick_needs_carry: assert property (@(posedge clk) disable iff (rst)
    tick60 |-> carry10);

  a_r10_no_pulse_in_reset: assert property (@(posedge clk)
    rst |-> (!carry10 && !tick60));
endmodule

bind sexagesimal_counter sexa_checker u_chk (
  .clk(clk), .rst(rst), .evt_en(evt_en), .units(units), .tens(tens),
  .carry10(carry10), .tick60(tick60)
);

// File: tb/sim_sexagesimal_counter.sv
module sim_sexagesimal_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_en = 1'b0;
  logic [3:0] units, tens;
  logic carry10, tick60;

  always #2 clk = ~clk;

  sexagesimal_counter u0 (
    .clk(clk), .rst(rst), .evt_en(evt_en), .units(units), .tens(tens),
    .carry10(carry10), .tick60(tick60)
  );

  typedef struct {
    logic [3:0] u;
    logic [3:0] t;
    logic       c;
    logic       k;
    logic       win;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int mu = 0, mt = 0;
  logic win = 1'b0;
  int carry_seen = 0, tick_seen = 0;
  logic done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: sets inputs after a falling edge, predicts outputs, steps model
  task automatic step(input logic en, input logic r);
    exp_t e;
    @(negedge clk);
    evt_en = en;
    rst    = r;
    e.u = 4'(mu);
    e.t = 4'(mt);
    e.c = en && !r && mu == 9;
    e.k = e.c && mt == 5;
    e.win = win;
    if (r)                       e.tag = "R1 R10";
    else if (!en)                e.tag = "R2";
    else if (mu == 9 && mt == 5) e.tag = "R8";
    else if (mu == 9)            e.tag = "R5 R7";
    else                         e.tag = "R3";
    q.push_back(e);
    if (r) begin
      mu = 0; mt = 0;
    end else if (en) begin
      if (mu == 9) begin
        mu = 0;
        mt = (mt == 5) ? 0 : mt + 1;
      end else mu = mu + 1;
    end
  endtask

  // monitor: compares one expected item per cycle, away from the edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(units == e.u, e.tag, "units", units, e.u);
        check(tens == e.t, e.tag, "tens", tens, e.t);
        check(carry10 == e.c, e.tag, "carry10", carry10, e.c);
        check(tick60 == e.k, e.tag, "tick60", tick60, e.k);
        check(units <= 4'd9, "R4", "units range", units, 9);
        check(tens <= 4'd5 && !tens[3], "R6", "tens range", tens, 5);
        if (e.win) begin
          carry_seen += int'(carry10);
          tick_seen  += int'(tick60);
        end
      end
    end
  end

  initial begin
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++)  step(1'b0, 1'b0);
    for (int i = 0; i < 130; i++) step(i % 3 != 1, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R9: window of 600 enabled events from 00
    win = 1'b1;
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0);
    win = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check(carry_seen == 60, "R9", "carry count", carry_seen, 60);
    check(tick_seen == 10, "R9", "tick count", tick_seen, 10);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(200000 * 4);
    join_any
    if (!done) check(1'b0, "watchdog", "finished", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule